// File: doc/BRIEF.md
# N-Queens Backtracking Search Engine

This block searches for placements of N non-attacking queens on an N by N board by depth-first backtracking in hardware. One queen goes in each column. Each column tries its rows from the lowest upward, and a column with no legal row sends the search back to the previous column, which then resumes from the row just above its old queen. The board is kept as one one-hot word per column. A candidate row is compared against every queen already placed in the same cycle, and a parameter sets how many adjacent candidate rows are examined together.

A run starts with a single-cycle `start` pulse while the engine is not busy. The mode input selects the run type. One type stops at the first full placement. The other type visits the whole tree and counts every solution. A pair of inputs confines the rows tried in column 0 to an inclusive range. Separate engines given disjoint ranges therefore cover disjoint parts of the solution space, and the sum of their counts is the full count. When the run ends, `done` rises and stays high until the next accepted start. The outputs give the first placement found and the number of solutions.

Top module: `nq_engine`

## Requirements
- R1: Any reported placement is legal: its rows are all different, and for any two columns i and j, row(i)-i differs from row(j)-j and row(i)+i differs from row(j)+j.
- R2: With `count_all`=0 the engine stops at the first solution in ascending row order. For N=8 with range 0..7 this is rows 0,4,7,5,2,6,1,3 for columns 0..7, and with range 1..7 it is 1,3,5,7,2,0,6,4.
- R3: With `count_all`=1 the engine counts every solution over the full range: 92 for N=8, 4 for N=6, 10 for N=5.
- R4: Only rows from `first_lo` to `first_hi` inclusive are tried in column 0. For N=8 the range 0..0 gives 4 solutions, 1..1 gives 8, and both 0..3 and 4..7 give 46.
- R5: An empty range (`first_lo` > `first_hi`) ends with `done`=1, `found`=0, a count of 0 and an all-zero placement.
- R6: The number of candidate rows tested per cycle (parameter R) does not change the results. N=6 with R=1 and N=5 with R=3 give the counts in R3 and the first solutions 1,3,5,0,2,4 and 0,2,4,1,3.
- R7: A start accepted while not busy makes `busy`=1 and `done`=0 from the next cycle. `busy` and `done` are never both high. `done` and the outputs hold until the next start.
- R8: `start`, `count_all` and the range inputs are ignored while `busy` is high. The run in progress finishes with the settings latched at its start.
- R9: After reset, `busy`, `done` and `found` are 0 and `sol_count` is 0.
- R10: In first-solution mode a successful run ends with `found`=1 and `sol_count`=1.
- R11: `placement` carries the row of column c in bits [c*W +: W], where W = clog2(N). The first solution found is also captured in counting mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; honoured only when not busy |
| count_all | input | 1 | 0: stop at first solution; 1: count all solutions |
| first_lo | input | W | Lowest row tried in column 0 |
| first_hi | input | W | Highest row tried in column 0 |
| busy | output | 1 | Search in progress |
| done | output | 1 | Run finished; held until next start |
| found | output | 1 | At least one solution was found in the last run |
| placement | output | N*W | Rows of the first solution, column c at [c*W +: W] |
| sol_count | output | CW | Number of solutions found |

## Verification
The bench targets the backtrack resume point, a window of candidate rows that runs past the last row, range limits on column 0, an empty range, and start pulses that arrive mid-run. If the resume point were wrong, the engine would revisit or skip rows, and the count of 92 and the split counts 4, 8 and 46 would come out wrong. If the window were not clipped at row N-1, it would test phantom rows, and the N=5 engine with three rows per cycle would miscount. If a mid-run start were accepted, the count would restart or the run would switch mode, so the result would no longer be 92 with a held `done`.

// File: rtl/nq_engine.sv
module nq_engine #(
  parameter int N  = 8,
  parameter int R  = 2,
  parameter int CW = 32,
  localparam int RW = (N > 1) ? $clog2(N) : 1,
  localparam int BW = $clog2(N + R + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             count_all,
  input  logic [RW-1:0]    first_lo,
  input  logic [RW-1:0]    first_hi,
  output logic             busy,
  output logic             done,
  output logic             found,
  output logic [N*RW-1:0]  placement,
  output logic [CW-1:0]    sol_count
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t           st;
  logic [N-1:0]  board [N];
  logic [RW-1:0] fsol  [N];
  logic [RW-1:0] col;
  logic [BW-1:0] base;
  logic [RW-1:0] lo_q, hi_q;
  logic          all_q;
  logic          found_q;

  logic [N-1:0]  attack;
  logic          hit;
  logic [RW-1:0] hit_row;
  logic          exhausted;
  logic          last_col;
  logic [RW-1:0] pcol;

  function automatic logic [RW-1:0] enc(input logic [N-1:0] w);
    enc = '0;
    for (int i = 0; i < N; i++)
      if (w[i]) enc = RW'(i);
  endfunction

  always_comb begin
    attack = '0;
    for (int k = 0; k < N; k++)
      if (k < int'(col))
        attack = attack | board[k] | (board[k] << (int'(col) - k)) | (board[k] >> (int'(col) - k));
  end

  always_comb begin
    hit = 1'b0;
    hit_row = '0;
    for (int i = R - 1; i >= 0; i--) begin
      int row;
      row = int'(base) + i;
      if (row < N)
        if (!attack[row[RW-1:0]] &&
            (col != '0 || (row >= int'(lo_q) && row <= int'(hi_q)))) begin
          hit = 1'b1;
          hit_row = RW'(row);
        end
    end
  end

  assign exhausted = !hit && (int'(base) + R >= N);
  assign last_col  = (col == RW'(N - 1));
  assign pcol      = col - RW'(1);

  assign busy  = (st == S_RUN);
  assign done  = (st == S_FIN);
  assign found = found_q;

  for (genvar c = 0; c < N; c++) begin : g_plc
    assign placement[c*RW +: RW] = fsol[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      col       <= '0;
      base      <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      all_q     <= 1'b0;
      found_q   <= 1'b0;
      sol_count <= '0;
      for (int c = 0; c < N; c++) begin
        board[c] <= '0;
        fsol[c]  <= '0;
      end
    end else if (st != S_RUN) begin
      if (start) begin
        st        <= S_RUN;
        col       <= '0;
        base      <= '0;
        lo_q      <= first_lo;
        hi_q      <= first_hi;
        all_q     <= count_all;
        found_q   <= 1'b0;
        sol_count <= '0;
        for (int c = 0; c < N; c++) begin
          board[c] <= '0;
          fsol[c]  <= '0;
        end
      end
    end else if (hit) begin
      if (last_col) begin
        sol_count <= sol_count + CW'(1);
        if (!found_q) begin
          found_q <= 1'b1;
          for (int c = 0; c < N; c++)
            fsol[c] <= (c == N - 1) ? hit_row : enc(board[c]);
        end
        if (!all_q) st <= S_FIN;
        else        base <= BW'(hit_row) + BW'(1);
      end else begin
        board[col] <= N'(1) << hit_row;
        col        <= col + RW'(1);
        base       <= '0;
      end
    end else if (exhausted) begin
      if (col == '0) begin
        st <= S_FIN;
      end else begin
        board[pcol] <= '0;
        col         <= pcol;
        base        <= BW'(enc(board[pcol])) + BW'(1);
      end
    end else begin
      base <= base + BW'(R);
    end
  end

endmodule

// File: rtl/nq_engine_chk.sv
module nq_engine_chk #(
  parameter int N  = 8,
  parameter int RW = 3,
  parameter int CW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            found,
  input logic [N*RW-1:0] placement,
  input logic [CW-1:0]   sol_count
);

  function automatic logic legal(input logic [N*RW-1:0] p);
    legal = 1'b1;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        int ri, rj;
        ri = int'(p[i*RW +: RW]);
        rj = int'(p[j*RW +: RW]);
        if (ri == rj || ri - i == rj - j || ri + i == rj + j) legal = 1'b0;
      end
  endfunction

  AST_NO_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R7
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done)); // R7
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R7
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(sol_count)); // R7
  AST_COUNT_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (sol_count >= $past(sol_count))); // R8
  AST_LEGAL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> legal(placement)); // R1

endmodule

bind nq_engine nq_engine_chk #(.N(N), .RW(RW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .found(found), .placement(placement), .sol_count(sol_count)
);

// File: tb/nq_engine_tb_top.sv
`timescale 1ns/1ps
module nq_engine_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit fin = 1'b0;

  logic        start = 1'b0, all_m = 1'b0;
  logic [2:0]  lo = '0, hi = '0;
  logic        busy, done, found;
  logic [23:0] plc;
  logic [31:0] cnt;

  nq_engine #(.N(8), .R(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .count_all(all_m),
    .first_lo(lo), .first_hi(hi), .busy(busy), .done(done),
    .found(found), .placement(plc), .sol_count(cnt));

  logic        start_b = 1'b0, all_b = 1'b0;
  logic        busy_b, done_b, found_b;
  logic [17:0] plc_b;
  logic [31:0] cnt_b;

  nq_engine #(.N(6), .R(1)) dut_b (
    .clk(clk), .rst_n(rst_n), .start(start_b), .count_all(all_b),
    .first_lo(3'd0), .first_hi(3'd5), .busy(busy_b), .done(done_b),
    .found(found_b), .placement(plc_b), .sol_count(cnt_b));

  logic        start_c = 1'b0, all_c = 1'b0;
  logic        busy_c, done_c, found_c;
  logic [14:0] plc_c;
  logic [31:0] cnt_c;

  nq_engine #(.N(5), .R(3)) dut_c (
    .clk(clk), .rst_n(rst_n), .start(start_c), .count_all(all_c),
    .first_lo(3'd0), .first_hi(3'd4), .busy(busy_c), .done(done_c),
    .found(found_c), .placement(plc_c), .sol_count(cnt_c));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] p8(input int a0, a1, a2, a3, a4, a5, a6, a7);
    p8 = {a7[2:0], a6[2:0], a5[2:0], a4[2:0], a3[2:0], a2[2:0], a1[2:0], a0[2:0]};
  endfunction

  int          q_cnt[$];
  bit          q_fnd[$];
  logic [23:0] q_plc[$];
  bit          q_chkp[$];
  string       q_tag[$];

  initial begin
    bit pd;
    pd = 1'b0;
    forever begin
      @(negedge clk);
      if (done && !pd) begin
        if (q_cnt.size() == 0) begin
          chk("R7 unexpected done", 1, 0);
        end else begin
          int ec; bit ef; logic [23:0] ep; bit cp; string t;
          ec = q_cnt.pop_front(); ef = q_fnd.pop_front();
          ep = q_plc.pop_front(); cp = q_chkp.pop_front(); t = q_tag.pop_front();
          chk({t, " count"}, cnt, ec);
          chk({t, " found"}, found, ef);
          if (cp) chk({t, " placement R11"}, plc, ep);
        end
      end
      pd = done;
    end
  end

  task automatic run_main(input bit all, input int l, input int h, input int ec,
                          input bit ef, input logic [23:0] ep, input bit cp,
                          input string tag, input bit pulse);
    q_cnt.push_back(ec); q_fnd.push_back(ef); q_plc.push_back(ep);
    q_chkp.push_back(cp); q_tag.push_back(tag);
    @(negedge clk);
    all_m = all; lo = l[2:0]; hi = h[2:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy after start", busy, 1);
    chk("R7 done low after start", done, 0);
    if (pulse) begin
      repeat (10) @(negedge clk);
      all_m = ~all; lo = 3'd5; hi = 3'd6; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8 still busy", busy, 1);
    end
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    chk({tag, " R7 done held"}, done, 1);
    chk({tag, " R7 count held"}, cnt, ec);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 busy", busy, 0);
    chk("R9 done", done, 0);
    chk("R9 found", found, 0);
    chk("R9 count", cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_main(1, 0, 7, 92, 1, p8(0,4,7,5,2,6,1,3), 1, "R3 all N8", 0);
    run_main(0, 0, 7, 1, 1, p8(0,4,7,5,2,6,1,3), 1, "R2 R10 first N8", 0);
    run_main(1, 0, 0, 4, 1, p8(0,4,7,5,2,6,1,3), 1, "R4 range 0..0", 0);
    run_main(1, 1, 1, 8, 1, p8(1,3,5,7,2,0,6,4), 1, "R4 range 1..1", 0);
    run_main(1, 0, 3, 46, 1, p8(0,4,7,5,2,6,1,3), 1, "R4 range 0..3", 0);
    run_main(1, 4, 7, 46, 1, '0, 0, "R4 range 4..7", 0);
    run_main(0, 1, 7, 1, 1, p8(1,3,5,7,2,0,6,4), 1, "R2 first from 1", 0);
    run_main(1, 5, 2, 0, 0, '0, 1, "R5 empty range", 0);
    run_main(1, 0, 7, 92, 1, p8(0,4,7,5,2,6,1,3), 1, "R8 start ignored", 1);

    @(negedge clk); all_b = 1'b1; start_b = 1'b1; all_c = 1'b1; start_c = 1'b1;
    @(negedge clk); start_b = 1'b0; start_c = 1'b0;
    while (!(done_b && done_c)) @(negedge clk);
    chk("R6 R3 N6 R=1 count", cnt_b, 4);
    chk("R6 R3 N5 R=3 count", cnt_c, 10);

    @(negedge clk); all_b = 1'b0; start_b = 1'b1; all_c = 1'b0; start_c = 1'b1;
    @(negedge clk); start_b = 1'b0; start_c = 1'b0;
    while (!(done_b && done_c)) @(negedge clk);
    chk("R6 N6 first placement", plc_b, {3'd4, 3'd2, 3'd0, 3'd5, 3'd3, 3'd1});
    chk("R6 N5 first placement", plc_c, {3'd3, 3'd1, 3'd4, 3'd2, 3'd0});
    chk("R10 N6 first count", cnt_b, 1);
    chk("R10 N5 found", found_c, 1);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule